// File: doc/BRIEF.md
# Accumulator-Style Arithmetic and Logic Unit

This block is the execute stage of a small 8-bit accumulator processor. It owns the accumulator A, the two index registers X and Y, and an 8-bit processor status byte. On each rising clock edge with the enable high, it decodes one opcode. It combines the opcode with one operand byte supplied by the memory side, then updates the registers and flags that belong to that opcode class. Address generation, the stack pointer, memory sequencing and branch targets are handled elsewhere. The block only sees the operand value those parts deliver.

The result output is a separate register. It shows the new accumulator value after any opcode that writes A. After a read-modify-write opcode on a memory operand (shift, rotate, increment, decrement), it shows the modified operand instead, and A itself stays unchanged. Opcodes that only move data elsewhere, or that only steer control flow, leave every output as it was. Any code not listed below is treated that way. Decimal mode is not built: arithmetic is always binary, whatever the D flag holds.

Top module: `acc_alu_core`

## Requirements
- R1: Status bit positions are N=7, V=6, constant one=5, B=4, D=3, I=2, Z=1, C=0, and bit 5 reads 1 at all times. A synchronous reset (rst_n low at a rising edge) wins over any opcode and gives status 8'h22, with result, A, X and Y all zero.
- R2: While en is low, no register or flag changes, whatever opcode and operand are applied.
- R3: Loads and transfers (8'h10 load A, 8'h11 load X, 8'h12 load Y, 8'h13 A to X, 8'h14 A to Y, 8'h15 X to A, 8'h16 Y to A) write the target register and set Z and N from the moved value. Every write to A also appears on result.
- R4: Add (8'h20) writes A = A + operand + C. C receives the ninth bit. V is set when both inputs share a sign that the sum does not. Z and N follow the sum, and the D flag has no effect.
- R5: Subtract (8'h21) writes A = A - operand - (1 - C). C is set when no borrow occurs. V is set when the inputs differ in sign and the result sign differs from A. Z and N follow the result.
- R6: Compare of A (8'h28), X (8'h29) or Y (8'h2A) against the operand sets C when the register is unsigned greater than or equal to the operand. Z and N come from the 8-bit difference. No register and no result changes.
- R7: AND (8'h30), OR (8'h31) and XOR (8'h32) combine A with the operand into A and set Z and N from the outcome.
- R8: Bit test (8'h33) sets Z when A AND operand is zero, copies operand bit 7 to N and bit 6 to V, and changes no register.
- R9: Accumulator shifts 8'h40 shift left, 8'h41 shift right, 8'h42 rotate left, 8'h43 rotate right. Rotates take old C in at the vacated end, and the bit pushed out goes to C. Z and N follow the new A.
- R10: Memory shifts 8'h44 to 8'h47 apply the same four operations, in the same order, to the operand. They put the outcome on result and set C, Z and N, but leave A unchanged.
- R11: 8'h50 gives result = operand + 1 and 8'h51 gives result = operand - 1. 8'h52 and 8'h53 increment X and Y, and 8'h54 and 8'h55 decrement X and Y. Each touches only Z and N among the flags.
- R12: 8'h60, 8'h61 and 8'h62 set C, D and I. 8'h63, 8'h64, 8'h65 and 8'h66 clear C, D, I and V. 8'h72 sets B. Each changes only its one flag.
- R13: Status restore (8'h70 pull, 8'h71 interrupt return) loads all seven flags from the same-numbered operand bits, and bit 5 stays 1.
- R14: X to stack (8'h17), the idle code 8'h00 and every unlisted code leave result, status, A, X and Y unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Execute the presented opcode at this edge |
| opcode | input | 8 | Operation code |
| operand | input | DW | Operand byte from the memory side |
| result | output | DW | Accumulator-side result register |
| status | output | 8 | Processor status byte |
| x_out | output | DW | Index register X |
| y_out | output | DW | Index register Y |

## Verification
Two pairs of functions can meet in one cycle. Reset can coincide with an enabled load, and a low enable can coincide with a state-changing opcode such as a load or a status restore. The bench presents both combinations at an edge. At the next falling edge it judges that reset values won in the first case and that every output held in the second. A stateful vector walk also applies memory shifts and increments between accumulator operations. This shows that A survives when result carries a different value.

// File: rtl/acc_alu_pkg.sv
// Shared constants for the accumulator ALU: status bit positions,
// reset value and the opcode map. Assumes an 8-bit status byte.
package acc_alu_pkg;

    localparam int SB_N   = 7;
    localparam int SB_V   = 6;
    localparam int SB_ONE = 5;
    localparam int SB_B   = 4;
    localparam int SB_D   = 3;
    localparam int SB_I   = 2;
    localparam int SB_Z   = 1;
    localparam int SB_C   = 0;

    localparam logic [7:0] ST_RESET = 8'h22;

    localparam logic [7:0] OP_IDLE     = 8'h00;
    localparam logic [7:0] OP_LOAD_A   = 8'h10;
    localparam logic [7:0] OP_LOAD_X   = 8'h11;
    localparam logic [7:0] OP_LOAD_Y   = 8'h12;
    localparam logic [7:0] OP_A_TO_X   = 8'h13;
    localparam logic [7:0] OP_A_TO_Y   = 8'h14;
    localparam logic [7:0] OP_X_TO_A   = 8'h15;
    localparam logic [7:0] OP_Y_TO_A   = 8'h16;
    localparam logic [7:0] OP_X_TO_SP  = 8'h17;
    localparam logic [7:0] OP_ADD_C    = 8'h20;
    localparam logic [7:0] OP_SUB_B    = 8'h21;
    localparam logic [7:0] OP_CMP_A    = 8'h28;
    localparam logic [7:0] OP_CMP_X    = 8'h29;
    localparam logic [7:0] OP_CMP_Y    = 8'h2A;
    localparam logic [7:0] OP_AND      = 8'h30;
    localparam logic [7:0] OP_OR       = 8'h31;
    localparam logic [7:0] OP_XOR      = 8'h32;
    localparam logic [7:0] OP_BITTEST  = 8'h33;
    localparam logic [7:0] OP_SHL_A    = 8'h40;
    localparam logic [7:0] OP_SHR_A    = 8'h41;
    localparam logic [7:0] OP_ROTL_A   = 8'h42;
    localparam logic [7:0] OP_ROTR_A   = 8'h43;
    localparam logic [7:0] OP_SHL_M    = 8'h44;
    localparam logic [7:0] OP_SHR_M    = 8'h45;
    localparam logic [7:0] OP_ROTL_M   = 8'h46;
    localparam logic [7:0] OP_ROTR_M   = 8'h47;
    localparam logic [7:0] OP_INC_M    = 8'h50;
    localparam logic [7:0] OP_DEC_M    = 8'h51;
    localparam logic [7:0] OP_INC_X    = 8'h52;
    localparam logic [7:0] OP_INC_Y    = 8'h53;
    localparam logic [7:0] OP_DEC_X    = 8'h54;
    localparam logic [7:0] OP_DEC_Y    = 8'h55;
    localparam logic [7:0] OP_SET_C    = 8'h60;
    localparam logic [7:0] OP_SET_D    = 8'h61;
    localparam logic [7:0] OP_SET_I    = 8'h62;
    localparam logic [7:0] OP_CLR_C    = 8'h63;
    localparam logic [7:0] OP_CLR_D    = 8'h64;
    localparam logic [7:0] OP_CLR_I    = 8'h65;
    localparam logic [7:0] OP_CLR_V    = 8'h66;
    localparam logic [7:0] OP_PULL_ST  = 8'h70;
    localparam logic [7:0] OP_RET_INT  = 8'h71;
    localparam logic [7:0] OP_BREAK    = 8'h72;

    // Shift kind, taken from the two low opcode bits of the shift group.
    typedef enum logic [1:0] {
        SH_LEFT   = 2'd0,
        SH_RIGHT  = 2'd1,
        SH_ROTL   = 2'd2,
        SH_ROTR   = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/acc_alu_addsub.sv
// Binary adder/subtractor with carry in.
// Subtraction is formed as lhs + ~rhs + carry_in, so carry_out means
// "no borrow". Overflow is the signed overflow of that sum.
module acc_alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          carry_in,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          carry_out,
    output logic          overflow
);

    logic [DW-1:0] rhs_eff;

    // Form the effective second input and the extended sum.
    always_comb begin
        rhs_eff = sub ? ~rhs : rhs;
        {carry_out, sum} = {1'b0, lhs} + {1'b0, rhs_eff} + {{DW{1'b0}}, carry_in};
        overflow = (lhs[DW-1] == rhs_eff[DW-1]) && (sum[DW-1] != lhs[DW-1]);
    end

endmodule

// File: rtl/acc_alu_compare.sv
// Unsigned comparison of a register against the operand.
// Produces the difference and a "register >= operand" bit.
module acc_alu_compare #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] diff,
    output logic          no_borrow
);

    // Subtract via two's complement; the carry out is the ">=" answer.
    always_comb begin
        {no_borrow, diff} = {1'b0, reg_val} + {1'b0, ~operand} + {{DW{1'b0}}, 1'b1};
    end

endmodule

// File: rtl/acc_alu_shifter.sv
// One-bit shift or rotate in either direction with carry in/out.
// Rotates insert carry_in at the vacated end; the ejected bit leaves
// on carry_out for every kind.
module acc_alu_shifter #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]             din,
    input  logic                      carry_in,
    input  acc_alu_pkg::shift_kind_e  kind,
    output logic [DW-1:0]             dout,
    output logic                      carry_out
);
    import acc_alu_pkg::*;

    // Select the shift kind.
    always_comb begin
        case (kind)
            SH_LEFT:  {carry_out, dout} = {din, 1'b0};
            SH_RIGHT: {dout, carry_out} = {1'b0, din};
            SH_ROTL:  {carry_out, dout} = {din, carry_in};
            default:  {dout, carry_out} = {carry_in, din};
        endcase
    end

endmodule

// File: rtl/acc_alu_next.sv
// Next-state logic of the ALU: decodes the opcode and computes the new
// A, X, Y, result and status values from the current ones. Purely
// combinational. Assumes DW >= 8, since status restore takes the low
// eight operand bits.
module acc_alu_next #(
    parameter int DW = 8
) (
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] res,
    input  logic [7:0]    st,
    output logic [DW-1:0] a_n,
    output logic [DW-1:0] x_n,
    output logic [DW-1:0] y_n,
    output logic [DW-1:0] res_n,
    output logic [7:0]    st_n
);
    import acc_alu_pkg::*;

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] add_sum, cmp_reg, cmp_diff, sh_src, sh_out;
    logic          add_co, add_ov, cmp_ge, sh_co;

    // Returns st with Z and N set from v.
    function automatic logic [7:0] with_nz(input logic [7:0] s, input logic [DW-1:0] v);
        logic [7:0] r;
        r = s;
        r[SB_N] = v[DW-1];
        r[SB_Z] = (v == '0);
        return r;
    endfunction

    acc_alu_addsub #(.DW(DW)) u_addsub (
        .lhs       (a),
        .rhs       (operand),
        .carry_in  (st[SB_C]),
        .sub       (opcode == OP_SUB_B),
        .sum       (add_sum),
        .carry_out (add_co),
        .overflow  (add_ov)
    );

    // Pick the register that a compare opcode tests.
    always_comb begin
        case (opcode)
            OP_CMP_X: cmp_reg = x;
            OP_CMP_Y: cmp_reg = y;
            default:  cmp_reg = a;
        endcase
    end

    acc_alu_compare #(.DW(DW)) u_cmp (
        .reg_val   (cmp_reg),
        .operand   (operand),
        .diff      (cmp_diff),
        .no_borrow (cmp_ge)
    );

    // Shift source: bit 2 of the shift group selects the memory operand.
    assign sh_src = opcode[2] ? operand : a;

    acc_alu_shifter #(.DW(DW)) u_shift (
        .din       (sh_src),
        .carry_in  (st[SB_C]),
        .kind      (shift_kind_e'(opcode[1:0])),
        .dout      (sh_out),
        .carry_out (sh_co)
    );

    // Decode the opcode and form every next-state value.
    always_comb begin
        a_n   = a;
        x_n   = x;
        y_n   = y;
        res_n = res;
        st_n  = st;
        case (opcode)
            OP_LOAD_A:  begin a_n = operand; res_n = operand; st_n = with_nz(st, operand); end
            OP_LOAD_X:  begin x_n = operand; st_n = with_nz(st, operand); end
            OP_LOAD_Y:  begin y_n = operand; st_n = with_nz(st, operand); end
            OP_A_TO_X:  begin x_n = a; st_n = with_nz(st, a); end
            OP_A_TO_Y:  begin y_n = a; st_n = with_nz(st, a); end
            OP_X_TO_A:  begin a_n = x; res_n = x; st_n = with_nz(st, x); end
            OP_Y_TO_A:  begin a_n = y; res_n = y; st_n = with_nz(st, y); end
            OP_ADD_C, OP_SUB_B: begin
                a_n = add_sum;
                res_n = add_sum;
                st_n = with_nz(st, add_sum);
                st_n[SB_C] = add_co;
                st_n[SB_V] = add_ov;
            end
            OP_CMP_A, OP_CMP_X, OP_CMP_Y: begin
                st_n = with_nz(st, cmp_diff);
                st_n[SB_C] = cmp_ge;
            end
            OP_AND:     begin a_n = a & operand; res_n = a & operand; st_n = with_nz(st, a & operand); end
            OP_OR:      begin a_n = a | operand; res_n = a | operand; st_n = with_nz(st, a | operand); end
            OP_XOR:     begin a_n = a ^ operand; res_n = a ^ operand; st_n = with_nz(st, a ^ operand); end
            OP_BITTEST: begin
                st_n[SB_Z] = ((a & operand) == '0);
                st_n[SB_N] = operand[DW-1];
                st_n[SB_V] = operand[DW-2];
            end
            OP_SHL_A, OP_SHR_A, OP_ROTL_A, OP_ROTR_A: begin
                a_n = sh_out;
                res_n = sh_out;
                st_n = with_nz(st, sh_out);
                st_n[SB_C] = sh_co;
            end
            OP_SHL_M, OP_SHR_M, OP_ROTL_M, OP_ROTR_M: begin
                res_n = sh_out;
                st_n = with_nz(st, sh_out);
                st_n[SB_C] = sh_co;
            end
            OP_INC_M:   begin res_n = operand + ONE; st_n = with_nz(st, operand + ONE); end
            OP_DEC_M:   begin res_n = operand - ONE; st_n = with_nz(st, operand - ONE); end
            OP_INC_X:   begin x_n = x + ONE; st_n = with_nz(st, x + ONE); end
            OP_INC_Y:   begin y_n = y + ONE; st_n = with_nz(st, y + ONE); end
            OP_DEC_X:   begin x_n = x - ONE; st_n = with_nz(st, x - ONE); end
            OP_DEC_Y:   begin y_n = y - ONE; st_n = with_nz(st, y - ONE); end
            OP_SET_C:   st_n[SB_C] = 1'b1;
            OP_SET_D:   st_n[SB_D] = 1'b1;
            OP_SET_I:   st_n[SB_I] = 1'b1;
            OP_CLR_C:   st_n[SB_C] = 1'b0;
            OP_CLR_D:   st_n[SB_D] = 1'b0;
            OP_CLR_I:   st_n[SB_I] = 1'b0;
            OP_CLR_V:   st_n[SB_V] = 1'b0;
            OP_BREAK:   st_n[SB_B] = 1'b1;
            OP_PULL_ST, OP_RET_INT: st_n = operand[7:0];
            default: ;
        endcase
        st_n[SB_ONE] = 1'b1;
    end

endmodule

// File: rtl/acc_alu_core.sv
// Top of the accumulator ALU. Holds A, X, Y, the result register and
// the status byte, and loads them from the next-state logic on each
// enabled rising edge. Reset is synchronous, active low, and has
// priority over the enable. Assumes DW >= 8.
module acc_alu_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] result,
    output logic [7:0]    status,
    output logic [DW-1:0] x_out,
    output logic [DW-1:0] y_out
);
    import acc_alu_pkg::*;

    logic [DW-1:0] a_q, x_q, y_q, res_q;
    logic [7:0]    st_q;
    logic [DW-1:0] a_d, x_d, y_d, res_d;
    logic [7:0]    st_d;

    acc_alu_next #(.DW(DW)) u_next (
        .opcode  (opcode),
        .operand (operand),
        .a       (a_q),
        .x       (x_q),
        .y       (y_q),
        .res     (res_q),
        .st      (st_q),
        .a_n     (a_d),
        .x_n     (x_d),
        .y_n     (y_d),
        .res_n   (res_d),
        .st_n    (st_d)
    );

    // Architectural state: reset, or take the next state when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            x_q   <= '0;
            y_q   <= '0;
            res_q <= '0;
            st_q  <= ST_RESET;
        end else if (en) begin
            a_q   <= a_d;
            x_q   <= x_d;
            y_q   <= y_d;
            res_q <= res_d;
            st_q  <= st_d;
        end
    end

    assign result = res_q;
    assign status = st_q;
    assign x_out  = x_q;
    assign y_out  = y_q;

endmodule

// File: rtl/acc_alu_core_chk.sv
// Property checker for acc_alu_core, attached by bind. Observes the
// top-level ports only.
module acc_alu_core_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [7:0]    opcode,
    input logic [DW-1:0] operand,
    input logic [DW-1:0] result,
    input logic [7:0]    status,
    input logic [DW-1:0] x_out,
    input logic [DW-1:0] y_out
);
    import acc_alu_pkg::*;

    // R1: the constant status bit is always one.
    a_r1_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_ONE]);

    // R1: the edge after a reset edge shows the reset values.
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status == ST_RESET && result == '0 && x_out == '0 && y_out == '0));

    // R2: a disabled edge changes nothing.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(result) && $stable(status) && $stable(x_out) && $stable(y_out)));

    // R6: compares leave result and index registers alone.
    a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        en && (opcode == OP_CMP_A || opcode == OP_CMP_X || opcode == OP_CMP_Y)
        |=> ($stable(result) && $stable(x_out) && $stable(y_out)));

    // R8: bit test copies the two top operand bits to N and V.
    a_r8_bit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        en && opcode == OP_BITTEST
        |=> (status[SB_N] == $past(operand[DW-1]) && status[SB_V] == $past(operand[DW-2]) && $stable(result)));

    // R10: memory shifts leave X and Y untouched.
    a_r10_mem_shift_idx: assert property (@(posedge clk) disable iff (!rst_n)
        en && opcode[7:2] == 6'b010001 |=> ($stable(x_out) && $stable(y_out)));

    // R13: status restore takes the operand with bit 5 forced.
    a_r13_restore: assert property (@(posedge clk) disable iff (!rst_n)
        en && (opcode == OP_PULL_ST || opcode == OP_RET_INT)
        |=> status == ($past(operand[7:0]) | 8'h20));

    // R14: passive opcodes change no output.
    a_r14_passive: assert property (@(posedge clk) disable iff (!rst_n)
        en && (opcode == OP_X_TO_SP || opcode == OP_IDLE)
        |=> ($stable(result) && $stable(status) && $stable(x_out) && $stable(y_out)));

endmodule

bind acc_alu_core acc_alu_core_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .opcode  (opcode),
    .operand (operand),
    .result  (result),
    .status  (status),
    .x_out   (x_out),
    .y_out   (y_out)
);

// File: tb/sim_acc_alu_core.sv
// Bench for acc_alu_core: a stateful vector table walked from reset,
// then directed checks on enable, reset priority and borrow corners.
module sim_acc_alu_core;
    import acc_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [7:0] opcode;
    logic [7:0] operand;
    logic [7:0] result, status, x_out, y_out;

    int n_run  = 0;
    int n_fail = 0;

    acc_alu_core #(.DW(8)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .opcode  (opcode),
        .operand (operand),
        .result  (result),
        .status  (status),
        .x_out   (x_out),
        .y_out   (y_out)
    );

    always #2ns clk = ~clk;

    // {req, opcode, operand, exp result, exp status, exp x, exp y}
    localparam int NV = 55;
    localparam logic [55:0] VEC [NV] = '{
        {8'd3,  OP_LOAD_A,  8'h80, 8'h80, 8'hA0, 8'h00, 8'h00}, // R3
        {8'd4,  OP_ADD_C,   8'h80, 8'h00, 8'h63, 8'h00, 8'h00}, // R4 neg+neg wraps
        {8'd4,  OP_ADD_C,   8'h01, 8'h02, 8'h20, 8'h00, 8'h00}, // R4 carry in
        {8'd4,  OP_ADD_C,   8'h7F, 8'h81, 8'hE0, 8'h00, 8'h00}, // R4 pos overflow
        {8'd12, OP_SET_C,   8'h00, 8'h81, 8'hE1, 8'h00, 8'h00}, // R12
        {8'd5,  OP_SUB_B,   8'h01, 8'h80, 8'hA1, 8'h00, 8'h00}, // R5
        {8'd5,  OP_SUB_B,   8'h01, 8'h7F, 8'h61, 8'h00, 8'h00}, // R5 overflow
        {8'd12, OP_CLR_C,   8'h00, 8'h7F, 8'h60, 8'h00, 8'h00}, // R12
        {8'd5,  OP_SUB_B,   8'h7E, 8'h00, 8'h23, 8'h00, 8'h00}, // R5 borrow in
        {8'd5,  OP_SUB_B,   8'h01, 8'hFF, 8'hA0, 8'h00, 8'h00}, // R5 borrow out
        {8'd3,  OP_LOAD_X,  8'h05, 8'hFF, 8'h20, 8'h05, 8'h00}, // R3
        {8'd6,  OP_CMP_X,   8'h05, 8'hFF, 8'h23, 8'h05, 8'h00}, // R6 equal
        {8'd6,  OP_CMP_X,   8'h06, 8'hFF, 8'hA0, 8'h05, 8'h00}, // R6 less
        {8'd6,  OP_CMP_A,   8'hFF, 8'hFF, 8'h23, 8'h05, 8'h00}, // R6
        {8'd3,  OP_LOAD_Y,  8'h00, 8'hFF, 8'h23, 8'h05, 8'h00}, // R3
        {8'd11, OP_DEC_Y,   8'h00, 8'hFF, 8'hA1, 8'h05, 8'hFF}, // R11 wrap down
        {8'd6,  OP_CMP_Y,   8'h80, 8'hFF, 8'h21, 8'h05, 8'hFF}, // R6 greater
        {8'd11, OP_INC_Y,   8'h00, 8'hFF, 8'h23, 8'h05, 8'h00}, // R11 wrap up
        {8'd11, OP_INC_X,   8'h00, 8'hFF, 8'h21, 8'h06, 8'h00}, // R11
        {8'd11, OP_DEC_X,   8'h00, 8'hFF, 8'h21, 8'h05, 8'h00}, // R11
        {8'd7,  OP_AND,     8'h0F, 8'h0F, 8'h21, 8'h05, 8'h00}, // R7
        {8'd7,  OP_OR,      8'hF0, 8'hFF, 8'hA1, 8'h05, 8'h00}, // R7
        {8'd7,  OP_XOR,     8'hFF, 8'h00, 8'h23, 8'h05, 8'h00}, // R7
        {8'd8,  OP_BITTEST, 8'hC0, 8'h00, 8'hE3, 8'h05, 8'h00}, // R8
        {8'd3,  OP_LOAD_A,  8'h41, 8'h41, 8'h61, 8'h05, 8'h00}, // R3
        {8'd8,  OP_BITTEST, 8'h01, 8'h41, 8'h21, 8'h05, 8'h00}, // R8
        {8'd9,  OP_SHL_A,   8'h00, 8'h82, 8'hA0, 8'h05, 8'h00}, // R9
        {8'd9,  OP_ROTL_A,  8'h00, 8'h04, 8'h21, 8'h05, 8'h00}, // R9
        {8'd9,  OP_ROTR_A,  8'h00, 8'h82, 8'hA0, 8'h05, 8'h00}, // R9
        {8'd9,  OP_SHR_A,   8'h00, 8'h41, 8'h20, 8'h05, 8'h00}, // R9
        {8'd10, OP_ROTR_M,  8'h01, 8'h00, 8'h23, 8'h05, 8'h00}, // R10
        {8'd10, OP_ROTL_M,  8'h80, 8'h01, 8'h21, 8'h05, 8'h00}, // R10
        {8'd10, OP_SHL_M,   8'h80, 8'h00, 8'h23, 8'h05, 8'h00}, // R10
        {8'd10, OP_SHR_M,   8'h03, 8'h01, 8'h21, 8'h05, 8'h00}, // R10
        {8'd10, OP_AND,     8'hFF, 8'h41, 8'h21, 8'h05, 8'h00}, // R10 A kept
        {8'd11, OP_INC_M,   8'hFF, 8'h00, 8'h23, 8'h05, 8'h00}, // R11
        {8'd11, OP_DEC_M,   8'h00, 8'hFF, 8'hA1, 8'h05, 8'h00}, // R11
        {8'd11, OP_INC_M,   8'h7F, 8'h80, 8'hA1, 8'h05, 8'h00}, // R11
        {8'd3,  OP_A_TO_X,  8'h00, 8'h80, 8'h21, 8'h41, 8'h00}, // R3
        {8'd3,  OP_LOAD_Y,  8'h90, 8'h80, 8'hA1, 8'h41, 8'h90}, // R3
        {8'd3,  OP_Y_TO_A,  8'h00, 8'h90, 8'hA1, 8'h41, 8'h90}, // R3
        {8'd3,  OP_X_TO_A,  8'h00, 8'h41, 8'h21, 8'h41, 8'h90}, // R3
        {8'd3,  OP_A_TO_Y,  8'h00, 8'h41, 8'h21, 8'h41, 8'h41}, // R3
        {8'd12, OP_SET_D,   8'h00, 8'h41, 8'h29, 8'h41, 8'h41}, // R12
        {8'd12, OP_SET_I,   8'h00, 8'h41, 8'h2D, 8'h41, 8'h41}, // R12
        {8'd12, OP_CLR_D,   8'h00, 8'h41, 8'h25, 8'h41, 8'h41}, // R12
        {8'd12, OP_CLR_I,   8'h00, 8'h41, 8'h21, 8'h41, 8'h41}, // R12
        {8'd12, OP_BREAK,   8'h00, 8'h41, 8'h31, 8'h41, 8'h41}, // R12
        {8'd13, OP_PULL_ST, 8'h00, 8'h41, 8'h20, 8'h41, 8'h41}, // R13
        {8'd13, OP_RET_INT, 8'hDF, 8'h41, 8'hFF, 8'h41, 8'h41}, // R13
        {8'd12, OP_CLR_V,   8'h00, 8'h41, 8'hBF, 8'h41, 8'h41}, // R12
        {8'd14, OP_X_TO_SP, 8'h00, 8'h41, 8'hBF, 8'h41, 8'h41}, // R14
        {8'd14, OP_IDLE,    8'h00, 8'h41, 8'hBF, 8'h41, 8'h41}, // R14
        {8'd14, 8'hFF,      8'h12, 8'h41, 8'hBF, 8'h41, 8'h41}, // R14 unlisted
        {8'd4,  OP_ADD_C,   8'h00, 8'h42, 8'h3C, 8'h41, 8'h41}  // R4 D ignored
    };

    // Compare all four outputs against expectations.
    task automatic check(input int req, input logic [7:0] er, input logic [7:0] es,
                         input logic [7:0] ex, input logic [7:0] ey);
        n_run++;
        if (result !== er || status !== es || x_out !== ex || y_out !== ey) begin
            n_fail++;
            $display("FAIL R%0d: res/st/x/y got %h %h %h %h expected %h %h %h %h",
                     req, result, status, x_out, y_out, er, es, ex, ey);
        end
    endtask

    // Present one opcode for one edge and wait to the next falling edge.
    task automatic step(input logic [7:0] op, input logic [7:0] opd);
        opcode  = op;
        operand = opd;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; opcode = OP_IDLE; operand = 8'h00;
        repeat (3) @(negedge clk);
        check(1, 8'h00, 8'h22, 8'h00, 8'h00);               // R1 reset state
        rst_n = 1'b1;
        en    = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][47:40], VEC[i][39:32]);
            check(int'(VEC[i][55:48]), VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
        end
        // R2: disabled load and disabled restore change nothing.
        en = 1'b0;
        step(OP_LOAD_A, 8'h55);
        check(2, 8'h42, 8'h3C, 8'h41, 8'h41);
        step(OP_RET_INT, 8'h00);
        check(2, 8'h42, 8'h3C, 8'h41, 8'h41);
        en = 1'b1;
        step(OP_LOAD_A, 8'h55);                              // R3 after re-enable
        check(3, 8'h55, 8'h3C, 8'h41, 8'h41);
        // R1: reset wins over an enabled load in the same cycle.
        rst_n = 1'b0;
        step(OP_LOAD_A, 8'h99);
        check(1, 8'h00, 8'h22, 8'h00, 8'h00);
        rst_n = 1'b1;
        step(OP_SUB_B, 8'h00);                               // R5 0-0-1 borrows
        check(5, 8'hFF, 8'hA0, 8'h00, 8'h00);
        step(OP_ADD_C, 8'h01);                               // R4 FF+1 carries
        check(4, 8'h00, 8'h23, 8'h00, 8'h00);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(4ns * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule